// File: doc/BRIEF.md
# 16-bit instruction decoder

This block turns one 16-bit instruction word into the control bundle for a small processor with a 16-bit datapath and eight registers. It is purely combinational. It finds the layout the word uses: jump with a long displacement, register-register-immediate, register-with-byte, or three-register. It pulls out the register specifiers and picks the register that actually gets written. It builds a full-width immediate, sign-extended or zero-extended as the operation class needs. It also selects an ALU operation and raises the memory, write-back, link, branch, jump, halt, return-from-exception and illegal-opcode strobes.

The five-bit major opcode is in bits [15:11]. Three-register words carry a two-bit function field in bits [1:0], and that field refines the ALU choice. The register file, the ALU, memory and hazard logic sit outside this block and consume its outputs directly.

Top module: `dec16_decoder`

## Requirements
- R1: `fmt_o` reports the layout as 0 = jump (opcodes 00100, 00110), 1 = two-register immediate (010xx, 10000, 10001, 10011, 101xx), 2 = register-with-byte (00101, 00111, 011xx, 10010, 11000), 3 = three-register (000xx, 11001, 11010, 11011, 111xx).
- R2: `rs_o` is always bits [10:8] and `rt_o` is always bits [7:5].
- R3: `rd_o` is bits [4:2] for opcodes 11001, 11010, 11011 and 111xx. It is bits [7:5] for 010xx, 10001 and 101xx, and bits [10:8] for 10010, 10011 and 11000. It is 7 for 00110 and 00111, and 0 for every other opcode.
- R4: `imm_o` is bits [4:0] sign-extended for 01000, 01001, 10000, 10001 and 10011. It is bits [7:0] sign-extended for 00101, 00111, 011xx and 11000, and bits [10:0] sign-extended for 00100 and 00110.
- R5: `imm_o` is bits [4:0] zero-extended for 01010 and 01011, and bits [7:0] zero-extended for 10010. It is 0 for all opcodes not named in R4, R5 or R6.
- R6: for the immediate shifts (101xx), `imm_o` carries only bits [3:0], zero-extended.
- R7: `alu_op_o` codes are 0 add, 1 reverse subtract, 2 xor, 3 and-not, 4 rotate left, 5 shift left, 6 rotate right, 7 shift right logical, 8 equal, 9 less, 10 less-or-equal, 11 carry-out, 12 bit reverse, 13 pass B, 14 byte shift-merge. The code is opcode[1:0] for 010xx, function[1:0] for 11011, 4 + opcode[1:0] for 101xx, 4 + function[1:0] for 11010 and 8 + opcode[1:0] for 111xx. It is 12 for 11001, 13 for 11000, 14 for 10010 and 0 otherwise.
- R8: `use_imm_o` is 1 exactly for 00101, 00111, 010xx, 100xx, 101xx and 11000.
- R9: `mem_rd_o` is 1 only for 10001, and `mem_wr_o` is 1 only for 10000 and 10011.
- R10: `reg_wr_o` is 1 exactly for 00110, 00111, 010xx, 10001, 10010, 10011, 101xx, 11000, 11001, 11010, 11011 and 111xx. `link_o` is 1 only for 00110 and 00111.
- R11: `branch_o` is 1 for 011xx, with `br_cond_o` = opcode[1:0] (0 zero, 1 nonzero, 2 negative, 3 non-negative) and 0 otherwise. `jump_o` is 1 for 001xx, and `jump_reg_o` is 1 for 00101 and 00111.
- R12: `halt_o` is 1 only for 00000 and `rti_o` only for 00011. The stop, no-operation and return opcodes (00000, 00001, 00011) raise no write or read enable.
- R13: `illegal_o` is 1 only for 00010, which raises no write, read, jump or branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | instruction word |
| fmt_o | output | 2 | layout code |
| rs_o | output | 3 | first source register |
| rt_o | output | 3 | second source / store-data register |
| rd_o | output | 3 | register written back |
| imm_o | output | DATA_W | extended immediate |
| use_imm_o | output | 1 | ALU B operand is the immediate |
| alu_op_o | output | 4 | ALU operation code |
| br_cond_o | output | 2 | branch test code |
| mem_rd_o | output | 1 | memory load |
| mem_wr_o | output | 1 | memory store |
| reg_wr_o | output | 1 | register write enable |
| link_o | output | 1 | write return address to link register |
| branch_o | output | 1 | conditional branch |
| jump_o | output | 1 | unconditional jump |
| jump_reg_o | output | 1 | jump target from register |
| halt_o | output | 1 | stop issue |
| rti_o | output | 1 | return from exception |
| illegal_o | output | 1 | undefined opcode |

## Verification
The assertions check cross-signal rules on every evaluation. Stop, no-operation, return and illegal words never enable a write. Load and store never coincide, and a link always targets register 7 on a jump. Store-with-update writes back to its base register, an immediate shift amount stays below 16, and at most one control-flow strobe is active. Only the bench's scenarios can show the exact values: the sign or zero fill of each immediate width, and the choice of destination field per opcode. The same holds for the ALU code chosen from the opcode or function bits, which the bench checks across every opcode with several bit patterns.

// File: rtl/dec16_pkg.sv
package dec16_pkg;

   typedef enum logic [1:0] {
      FMT_J  = 2'd0,
      FMT_I1 = 2'd1,
      FMT_I2 = 2'd2,
      FMT_R  = 2'd3
   } fmt_e;

   typedef enum logic [3:0] {
      ALU_ADD   = 4'd0,
      ALU_RSUB  = 4'd1,
      ALU_XOR   = 4'd2,
      ALU_ANDN  = 4'd3,
      ALU_ROL   = 4'd4,
      ALU_SLL   = 4'd5,
      ALU_ROR   = 4'd6,
      ALU_SRL   = 4'd7,
      ALU_SEQ   = 4'd8,
      ALU_SLT   = 4'd9,
      ALU_SLE   = 4'd10,
      ALU_SCO   = 4'd11,
      ALU_BREV  = 4'd12,
      ALU_PASSB = 4'd13,
      ALU_BMRG  = 4'd14,
      ALU_RSVD  = 4'd15
   } alu_e;

   typedef enum logic [2:0] {
      EXT_NONE = 3'd0,
      EXT_S5   = 3'd1,
      EXT_Z5   = 3'd2,
      EXT_SHM  = 3'd3,
      EXT_S8   = 3'd4,
      EXT_Z8   = 3'd5,
      EXT_S11  = 3'd6
   } ext_e;

   typedef enum logic [1:0] {
      RD_NONE = 2'd0,
      RD_LO   = 2'd1,
      RD_MID  = 2'd2,
      RD_HI   = 2'd3
   } rdsel_e;

   typedef struct packed {
      fmt_e   fmt;
      ext_e   ext;
      rdsel_e rd_sel;
      logic   use_imm;
      logic   mem_rd;
      logic   mem_wr;
      logic   reg_wr;
      logic   link;
      logic   branch;
      logic   jump;
      logic   jump_reg;
      logic   halt;
      logic   rti;
      logic   illegal;
   } ctl_t;

endpackage

// File: rtl/dec16_class.sv
module dec16_class
   import dec16_pkg::*;
(
   input  logic [4:0] opc_i,
   output ctl_t       ctl_o
);

   always_comb begin
      ctl_o = '{fmt: FMT_R, ext: EXT_NONE, rd_sel: RD_NONE, default: 1'b0};
      casez (opc_i)
         5'b00000: ctl_o.halt = 1'b1;
         5'b00001: ;
         5'b00010: ctl_o.illegal = 1'b1;
         5'b00011: ctl_o.rti = 1'b1;
         5'b00100: begin
            ctl_o.fmt  = FMT_J;
            ctl_o.ext  = EXT_S11;
            ctl_o.jump = 1'b1;
         end
         5'b00110: begin
            ctl_o.fmt    = FMT_J;
            ctl_o.ext    = EXT_S11;
            ctl_o.jump   = 1'b1;
            ctl_o.link   = 1'b1;
            ctl_o.reg_wr = 1'b1;
         end
         5'b00101: begin
            ctl_o.fmt      = FMT_I2;
            ctl_o.ext      = EXT_S8;
            ctl_o.use_imm  = 1'b1;
            ctl_o.jump     = 1'b1;
            ctl_o.jump_reg = 1'b1;
         end
         5'b00111: begin
            ctl_o.fmt      = FMT_I2;
            ctl_o.ext      = EXT_S8;
            ctl_o.use_imm  = 1'b1;
            ctl_o.jump     = 1'b1;
            ctl_o.jump_reg = 1'b1;
            ctl_o.link     = 1'b1;
            ctl_o.reg_wr   = 1'b1;
         end
         5'b010??: begin
            ctl_o.fmt     = FMT_I1;
            ctl_o.ext     = opc_i[1] ? EXT_Z5 : EXT_S5;
            ctl_o.use_imm = 1'b1;
            ctl_o.reg_wr  = 1'b1;
            ctl_o.rd_sel  = RD_MID;
         end
         5'b011??: begin
            ctl_o.fmt    = FMT_I2;
            ctl_o.ext    = EXT_S8;
            ctl_o.branch = 1'b1;
         end
         5'b10000: begin
            ctl_o.fmt     = FMT_I1;
            ctl_o.ext     = EXT_S5;
            ctl_o.use_imm = 1'b1;
            ctl_o.mem_wr  = 1'b1;
         end
         5'b10001: begin
            ctl_o.fmt     = FMT_I1;
            ctl_o.ext     = EXT_S5;
            ctl_o.use_imm = 1'b1;
            ctl_o.mem_rd  = 1'b1;
            ctl_o.reg_wr  = 1'b1;
            ctl_o.rd_sel  = RD_MID;
         end
         5'b10010: begin
            ctl_o.fmt     = FMT_I2;
            ctl_o.ext     = EXT_Z8;
            ctl_o.use_imm = 1'b1;
            ctl_o.reg_wr  = 1'b1;
            ctl_o.rd_sel  = RD_HI;
         end
         5'b10011: begin
            ctl_o.fmt     = FMT_I1;
            ctl_o.ext     = EXT_S5;
            ctl_o.use_imm = 1'b1;
            ctl_o.mem_wr  = 1'b1;
            ctl_o.reg_wr  = 1'b1;
            ctl_o.rd_sel  = RD_HI;
         end
         5'b101??: begin
            ctl_o.fmt     = FMT_I1;
            ctl_o.ext     = EXT_SHM;
            ctl_o.use_imm = 1'b1;
            ctl_o.reg_wr  = 1'b1;
            ctl_o.rd_sel  = RD_MID;
         end
         5'b11000: begin
            ctl_o.fmt     = FMT_I2;
            ctl_o.ext     = EXT_S8;
            ctl_o.use_imm = 1'b1;
            ctl_o.reg_wr  = 1'b1;
            ctl_o.rd_sel  = RD_HI;
         end
         default: begin
            ctl_o.reg_wr = 1'b1;
            ctl_o.rd_sel = RD_LO;
         end
      endcase
   end

endmodule

// File: rtl/dec16_imm.sv
module dec16_imm
   import dec16_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int FIELD_W = 11
) (
   input  logic [FIELD_W-1:0] field_i,
   input  ext_e               ext_i,
   output logic [DATA_W-1:0]  imm_o
);

   localparam int SHAMT_RAW = $clog2(DATA_W);
   localparam int SHAMT_W   = (SHAMT_RAW > 5) ? 5 : SHAMT_RAW;

   logic [3:0] keep_w;
   logic       fill_b;

   always_comb begin
      keep_w = 4'd0;
      fill_b = 1'b0;
      unique case (ext_i)
         EXT_S5:  begin keep_w = 4'd5;  fill_b = field_i[4];  end
         EXT_Z5:  keep_w = 4'd5;
         EXT_SHM: keep_w = 4'(SHAMT_W);
         EXT_S8:  begin keep_w = 4'd8;  fill_b = field_i[7];  end
         EXT_Z8:  keep_w = 4'd8;
         EXT_S11: begin keep_w = 4'd11; fill_b = field_i[10]; end
         default: ;
      endcase
   end

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b < FIELD_W) begin : g_field
         assign imm_o[b] = (4'(b) < keep_w) ? field_i[b] : fill_b;
      end else begin : g_fill
         assign imm_o[b] = fill_b;
      end
   end

endmodule

// File: rtl/dec16_alu.sv
module dec16_alu
   import dec16_pkg::*;
(
   input  logic [4:0] opc_i,
   input  logic [1:0] func_i,
   output alu_e       alu_o
);

   always_comb begin
      casez (opc_i)
         5'b010??: alu_o = alu_e'({2'b00, opc_i[1:0]});
         5'b11011: alu_o = alu_e'({2'b00, func_i});
         5'b101??: alu_o = alu_e'({2'b01, opc_i[1:0]});
         5'b11010: alu_o = alu_e'({2'b01, func_i});
         5'b111??: alu_o = alu_e'({2'b10, opc_i[1:0]});
         5'b11001: alu_o = ALU_BREV;
         5'b11000: alu_o = ALU_PASSB;
         5'b10010: alu_o = ALU_BMRG;
         default:  alu_o = ALU_ADD;
      endcase
   end

endmodule

// File: rtl/dec16_decoder.sv
module dec16_decoder
   import dec16_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int LINK_REG = 7
) (
   input  logic [15:0]       instr_i,
   output logic [1:0]        fmt_o,
   output logic [2:0]        rs_o,
   output logic [2:0]        rt_o,
   output logic [2:0]        rd_o,
   output logic [DATA_W-1:0] imm_o,
   output logic              use_imm_o,
   output logic [3:0]        alu_op_o,
   output logic [1:0]        br_cond_o,
   output logic              mem_rd_o,
   output logic              mem_wr_o,
   output logic              reg_wr_o,
   output logic              link_o,
   output logic              branch_o,
   output logic              jump_o,
   output logic              jump_reg_o,
   output logic              halt_o,
   output logic              rti_o,
   output logic              illegal_o
);

   localparam int OPC_W   = 5;
   localparam int REG_AW  = 3;
   localparam int FIELD_W = 16 - OPC_W;

   if (DATA_W < 16) begin : g_bad_width
      $error("dec16_decoder: DATA_W must be at least 16");
   end
   if (LINK_REG < 0 || LINK_REG >= (1 << REG_AW)) begin : g_bad_link
      $error("dec16_decoder: LINK_REG outside register range");
   end

   logic [OPC_W-1:0]   opc;
   logic [FIELD_W-1:0] field;
   ctl_t               ctl;
   alu_e               alu_sel;

   assign opc   = instr_i[15:11];
   assign field = instr_i[FIELD_W-1:0];

   dec16_class u_class (
      .opc_i (opc),
      .ctl_o (ctl)
   );

   dec16_imm #(
      .DATA_W  (DATA_W),
      .FIELD_W (FIELD_W)
   ) u_imm (
      .field_i (field),
      .ext_i   (ctl.ext),
      .imm_o   (imm_o)
   );

   dec16_alu u_alu (
      .opc_i  (opc),
      .func_i (instr_i[1:0]),
      .alu_o  (alu_sel)
   );

   always_comb begin
      if (ctl.link) begin
         rd_o = REG_AW'(LINK_REG);
      end else begin
         unique case (ctl.rd_sel)
            RD_LO:   rd_o = instr_i[4:2];
            RD_MID:  rd_o = instr_i[7:5];
            RD_HI:   rd_o = instr_i[10:8];
            default: rd_o = '0;
         endcase
      end
   end

   assign fmt_o      = ctl.fmt;
   assign rs_o       = instr_i[10:8];
   assign rt_o       = instr_i[7:5];
   assign use_imm_o  = ctl.use_imm;
   assign alu_op_o   = alu_sel;
   assign br_cond_o  = ctl.branch ? opc[1:0] : 2'b00;
   assign mem_rd_o   = ctl.mem_rd;
   assign mem_wr_o   = ctl.mem_wr;
   assign reg_wr_o   = ctl.reg_wr;
   assign link_o     = ctl.link;
   assign branch_o   = ctl.branch;
   assign jump_o     = ctl.jump;
   assign jump_reg_o = ctl.jump_reg;
   assign halt_o     = ctl.halt;
   assign rti_o      = ctl.rti;
   assign illegal_o  = ctl.illegal;

endmodule

// File: rtl/dec16_decoder_chk.sv
module dec16_decoder_chk #(
   parameter int DATA_W   = 16,
   parameter int LINK_REG = 7
) (
   input logic [15:0]       instr_i,
   input logic [2:0]        rs_o,
   input logic [2:0]        rd_o,
   input logic [DATA_W-1:0] imm_o,
   input logic              use_imm_o,
   input logic [3:0]        alu_op_o,
   input logic              mem_rd_o,
   input logic              mem_wr_o,
   input logic              reg_wr_o,
   input logic              link_o,
   input logic              branch_o,
   input logic              jump_o,
   input logic              jump_reg_o,
   input logic              halt_o,
   input logic              rti_o,
   input logic              illegal_o
);

   always_comb begin
      if (halt_o || rti_o || instr_i[15:11] == 5'b00001)
         a_r12_quiet: assert (!reg_wr_o && !mem_wr_o && !mem_rd_o)
            else $error("stop/no-op/return raised an enable");
      if (illegal_o)
         a_r13_illegal_quiet: assert (!reg_wr_o && !mem_wr_o && !mem_rd_o && !jump_o && !branch_o)
            else $error("illegal opcode raised an enable");
      a_r9_mem_excl: assert (!(mem_rd_o && mem_wr_o))
         else $error("load and store together");
      if (link_o)
         a_r10_link_r7: assert (reg_wr_o && jump_o && rd_o == 3'(LINK_REG))
            else $error("link without jump or wrong target");
      if (mem_wr_o && reg_wr_o)
         a_r3_update_base: assert (rd_o == rs_o)
            else $error("store-with-update not writing base");
      if (use_imm_o && alu_op_o[3:2] == 2'b01)
         a_r6_shamt: assert ((imm_o >> 4) == '0)
            else $error("shift amount wider than four bits");
      a_r11_one_flow: assert ($onehot0({branch_o, jump_o, halt_o, rti_o, illegal_o}))
         else $error("several control-flow strobes");
      if (jump_reg_o)
         a_r11_jreg_jump: assert (jump_o)
            else $error("register jump without jump");
   end

endmodule

bind dec16_decoder dec16_decoder_chk #(
   .DATA_W   (DATA_W),
   .LINK_REG (LINK_REG)
) u_chk (
   .instr_i    (instr_i),
   .rs_o       (rs_o),
   .rd_o       (rd_o),
   .imm_o      (imm_o),
   .use_imm_o  (use_imm_o),
   .alu_op_o   (alu_op_o),
   .mem_rd_o   (mem_rd_o),
   .mem_wr_o   (mem_wr_o),
   .reg_wr_o   (reg_wr_o),
   .link_o     (link_o),
   .branch_o   (branch_o),
   .jump_o     (jump_o),
   .jump_reg_o (jump_reg_o),
   .halt_o     (halt_o),
   .rti_o      (rti_o),
   .illegal_o  (illegal_o)
);

// File: tb/dec16_decoder_bench.sv
module dec16_decoder_bench;

   logic        clk = 1'b0;
   logic [15:0] instr = 16'h0000;

   logic [1:0]  fmt;
   logic [2:0]  rs, rt, rd;
   logic [15:0] imm;
   logic        use_imm;
   logic [3:0]  alu_op;
   logic [1:0]  br_cond;
   logic        mem_rd, mem_wr, reg_wr, link, branch, jump, jump_reg, halt, rti, illegal;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   dec16_decoder u_dec16_decoder (
      .instr_i    (instr),
      .fmt_o      (fmt),
      .rs_o       (rs),
      .rt_o       (rt),
      .rd_o       (rd),
      .imm_o      (imm),
      .use_imm_o  (use_imm),
      .alu_op_o   (alu_op),
      .br_cond_o  (br_cond),
      .mem_rd_o   (mem_rd),
      .mem_wr_o   (mem_wr),
      .reg_wr_o   (reg_wr),
      .link_o     (link),
      .branch_o   (branch),
      .jump_o     (jump),
      .jump_reg_o (jump_reg),
      .halt_o     (halt),
      .rti_o      (rti),
      .illegal_o  (illegal)
   );

   function automatic int sx(int v, int bits);
      int m = v % (1 << bits);
      if (m >= (1 << (bits - 1))) return (m - (1 << bits)) & 16'hFFFF;
      return m;
   endfunction

   function automatic bit in_set(int op, int lo, int hi);
      return (op >= lo) && (op <= hi);
   endfunction

   task automatic chk(string tag, string what, int act, int exp, logic [15:0] w);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s instr=%h actual=%0h expected=%0h", tag, what, w, act, exp);
      end
   endtask

   task automatic compare(logic [15:0] w);
      int op = int'(w[15:11]);
      int fn = int'(w[1:0]);
      int e_fmt, e_rd, e_imm, e_alu, e_use, e_rwr, e_link, e_br, e_brc, e_j, e_jr;
      string imm_tag;
      if (op == 4 || op == 6) e_fmt = 0;
      else if (op == 5 || op == 7 || in_set(op, 12, 15) || op == 18 || op == 24) e_fmt = 2;
      else if (in_set(op, 8, 11) || op == 16 || op == 17 || op == 19 || in_set(op, 20, 23)) e_fmt = 1;
      else e_fmt = 3;

      if (op >= 25) e_rd = int'(w[4:2]);
      else if (in_set(op, 8, 11) || op == 17 || in_set(op, 20, 23)) e_rd = int'(w[7:5]);
      else if (op == 18 || op == 19 || op == 24) e_rd = int'(w[10:8]);
      else if (op == 6 || op == 7) e_rd = 7;
      else e_rd = 0;

      imm_tag = "R5";
      if (op == 8 || op == 9 || op == 16 || op == 17 || op == 19) begin e_imm = sx(int'(w[4:0]), 5); imm_tag = "R4"; end
      else if (op == 5 || op == 7 || in_set(op, 12, 15) || op == 24) begin e_imm = sx(int'(w[7:0]), 8); imm_tag = "R4"; end
      else if (op == 4 || op == 6) begin e_imm = sx(int'(w[10:0]), 11); imm_tag = "R4"; end
      else if (op == 10 || op == 11) e_imm = int'(w[4:0]);
      else if (op == 18) e_imm = int'(w[7:0]);
      else if (in_set(op, 20, 23)) begin e_imm = int'(w[3:0]); imm_tag = "R6"; end
      else e_imm = 0;

      if (in_set(op, 8, 11)) e_alu = op - 8;
      else if (op == 27) e_alu = fn;
      else if (in_set(op, 20, 23)) e_alu = 4 + op - 20;
      else if (op == 26) e_alu = 4 + fn;
      else if (op >= 28) e_alu = 8 + op - 28;
      else if (op == 25) e_alu = 12;
      else if (op == 24) e_alu = 13;
      else if (op == 18) e_alu = 14;
      else e_alu = 0;

      e_use  = int'(op == 5 || op == 7 || in_set(op, 8, 11) || in_set(op, 16, 24));
      e_rwr  = int'(op == 6 || op == 7 || in_set(op, 8, 11) || in_set(op, 17, 31));
      e_link = int'(op == 6 || op == 7);
      e_br   = int'(in_set(op, 12, 15));
      e_brc  = e_br ? op - 12 : 0;
      e_j    = int'(in_set(op, 4, 7));
      e_jr   = int'(op == 5 || op == 7);

      chk("R1", "fmt", int'(fmt), e_fmt, w);
      chk("R2", "rs", int'(rs), int'(w[10:8]), w);
      chk("R2", "rt", int'(rt), int'(w[7:5]), w);
      chk("R3", "rd", int'(rd), e_rd, w);
      chk(imm_tag, "imm", int'(imm), e_imm, w);
      chk("R7", "alu", int'(alu_op), e_alu, w);
      chk("R8", "use_imm", int'(use_imm), e_use, w);
      chk("R9", "mem_rd", int'(mem_rd), int'(op == 17), w);
      chk("R9", "mem_wr", int'(mem_wr), int'(op == 16 || op == 19), w);
      if (op == 2) chk("R13", "reg_wr", int'(reg_wr), 0, w);
      else if (op < 4) chk("R12", "reg_wr", int'(reg_wr), 0, w);
      else chk("R10", "reg_wr", int'(reg_wr), e_rwr, w);
      chk("R10", "link", int'(link), e_link, w);
      chk("R11", "branch", int'(branch), e_br, w);
      chk("R11", "br_cond", int'(br_cond), e_brc, w);
      chk("R11", "jump", int'(jump), e_j, w);
      chk("R11", "jump_reg", int'(jump_reg), e_jr, w);
      chk("R12", "halt", int'(halt), int'(op == 0), w);
      chk("R12", "rti", int'(rti), int'(op == 3), w);
      chk("R13", "illegal", int'(illegal), int'(op == 2), w);
   endtask

   task automatic apply(logic [15:0] w);
      @(posedge clk);
      #1 instr = w;
      @(negedge clk);
      compare(w);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      repeat (3) @(posedge clk);
      // R12 idle word (all zero) decodes as stop with no enables
      @(negedge clk);
      compare(16'h0000);
      // R4 five-bit negative offset
      apply(16'h4010);
      chk("R4", "addi imm -16", int'(imm), 16'hFFF0, 16'h4010);
      // R5 logical immediate zero-filled
      apply(16'h501F);
      chk("R5", "xori imm", int'(imm), 16'h001F, 16'h501F);
      // R5 byte-merge immediate zero-filled
      apply(16'h9080);
      chk("R5", "slbi imm", int'(imm), 16'h0080, 16'h9080);
      // R4 byte load sign-filled, destination is the high field (R3)
      apply(16'hC580);
      chk("R4", "lbi imm", int'(imm), 16'hFF80, 16'hC580);
      chk("R3", "lbi rd", int'(rd), 5, 16'hC580);
      // R4 long displacement
      apply(16'h2400);
      chk("R4", "j disp", int'(imm), 16'hFC00, 16'h2400);
      // R6 shift amount keeps four bits
      apply(16'hA81F);
      chk("R6", "slli amt", int'(imm), 16'h000F, 16'hA81F);
      // R3 R9 store with update writes base
      apply(16'h9B25);
      chk("R3", "stu rd", int'(rd), 3, 16'h9B25);
      chk("R9", "stu wr", int'(mem_wr), 1, 16'h9B25);
      // R10 link on jal
      apply(16'h3123);
      chk("R10", "jal rd", int'(rd), 7, 16'h3123);
      // R7 three-register shift right logical by function bits
      apply(16'hD01F);
      chk("R7", "srl alu", int'(alu_op), 7, 16'hD01F);
      // R12 R13 no-op, illegal, return
      apply(16'h0FFF);
      apply(16'h17FF);
      apply(16'h1FFF);
      // sweep every opcode with mixed low bits
      for (int op = 0; op < 32; op++) begin
         for (int k = 0; k < 6; k++) begin
            logic [10:0] low;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (k)
               0: low = 11'h000;
               1: low = 11'h7FF;
               2: low = 11'h400;
               default: low = lfsr[10:0];
            endcase
            apply({op[4:0], low});
         end
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule